// File: doc/BRIEF.md
# Framed Manchester Serial Transmitter

This block takes a parallel data word through a valid/ready load handshake and sends it out on one serial line as a Manchester-coded frame. All line timing is built from half-bit slots. The length of each slot comes from a clock divider value that is captured when the word is loaded.

Each frame starts with a preamble. The line stays high for a fixed number of half-bit slots, then drops low for exactly one slot. A receiver treats that long high as a single high symbol, and it discards both preamble symbols. After the preamble, each data bit takes two half-bit slots. Bit 0 goes first. A one is sent as low followed by high, and a zero is sent as high followed by low.

Between frames the line rests high and the ready flag is asserted. When the last slot of a frame ends, a one-cycle done pulse marks the moment the block can take the next word.

Top module: `manch_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `line_o` high, `ready_o` high and `done_o` low, and any frame in progress is abandoned. The half-bit counter is cleared, so the next frame starts with full-length slots.
- R2: Every half-bit slot of a frame lasts exactly `div_i + 1` clock cycles, using the `div_i` value captured at load.
- R3: A frame opens with `PRE_HALVES` slots (default 3, never fewer than 3) of high level, followed by exactly one slot of low level.
- R4: A data bit of 1 is sent as a low slot followed by a high slot. A data bit of 0 is sent as a high slot followed by a low slot.
- R5: Data bits are sent least significant first. The first slot pair after the preamble carries bit 0, and the last pair carries bit `WORD_W-1`.
- R6: A frame is `PRE_HALVES + 1 + 2*WORD_W` slots long. `ready_o` goes low in the cycle after a word is accepted and stays low until the last slot has ended. In the cycle where `ready_o` returns high, `done_o` is high for exactly one cycle.
- R7: A word is accepted only on a clock edge where `valid_i` is high and `ready_o` is high. `valid_i`, `data_i` and `div_i` driven while `ready_o` is low have no effect on the frame on the line. While `ready_o` is high, `line_o` is high.
- R8: The divider is sampled only at load. Changing `div_i` during a frame leaves the slot lengths of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | WORD_W | Word to send |
| valid_i | input | 1 | Load request for `data_i` |
| div_i | input | DIV_W | Half-bit slot length minus one, in clock cycles |
| line_o | output | 1 | Manchester serial line, idles high |
| ready_o | output | 1 | High when a new word can be accepted |
| done_o | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench sends every possible 8-bit word with the fastest divider and compares the line against a computed slot pattern in every cycle. This catches swapped half-bit polarity (each data slot would be inverted) and most-significant-first ordering (the slot pairs would come out mirrored). A few words are repeated at larger dividers to expose an off-by-one slot length, which would shift every later slot and so move the end of the frame. One frame is hit mid-flight with a new word, a new valid and a new divider; a design that reloads while busy would change its bit pattern or slot timing at that point. A reset in the middle of a frame must return the line and ready high at once, and the frame that follows must still have correct slot lengths; a counter that is not cleared would make its first slot too short or too long.

// File: rtl/manch_tx.sv
module manch_tx #(
  parameter int WORD_W     = 8,
  parameter int DIV_W      = 8,
  parameter int PRE_HALVES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              line_o,
  output logic              ready_o,
  output logic              done_o
);
  localparam int SLOTS = PRE_HALVES + 1 + 2 * WORD_W;
  localparam int IW    = $clog2(SLOTS);

  logic              busy;
  logic [IW-1:0]     idx;
  logic [DIV_W-1:0]  cnt, divq;
  logic [WORD_W-1:0] sh;

  wire           tick   = busy && (cnt == '0);
  wire           last   = idx == IW'(SLOTS - 1);
  wire           in_pre = idx < IW'(PRE_HALVES);
  wire           is_gap = idx == IW'(PRE_HALVES);
  wire [IW-1:0]  dpos   = idx - IW'(PRE_HALVES + 1);
  wire           second = dpos[0];
  wire           load   = valid_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      divq   <= '0;
      sh     <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
        cnt  <= div_i;
        divq <= div_i;
        sh   <= data_i;
      end else if (busy) begin
        if (tick) begin
          cnt <= divq;
          if (last) begin
            busy   <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            if (!in_pre && !is_gap && second) sh <= sh >> 1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign ready_o = !busy;
  assign line_o  = !busy || in_pre || (!is_gap && (second ? sh[0] : !sh[0]));
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk (
  input logic clk,
  input logic rst,
  input logic valid_i,
  input logic line_o,
  input logic ready_o,
  input logic done_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (line_o && ready_o && !done_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ready_o && $past(!ready_o)));

  a_r6_busy_after_load: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ready_o) |=> !ready_o);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> line_o);
endmodule

bind manch_tx manch_tx_chk u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i),
  .line_o(line_o), .ready_o(ready_o), .done_o(done_o)
);

// File: tb/sim_manch_tx.sv
module sim_manch_tx;
  localparam int W = 8, DW = 8, PRE = 3;
  localparam int S = PRE + 1 + 2 * W;

  logic clk = 0, rst = 1, valid = 0;
  logic [W-1:0] data = '0;
  logic [DW-1:0] div = '0;
  logic line, ready, done;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  manch_tx #(.WORD_W(W), .DIV_W(DW), .PRE_HALVES(PRE)) u0 (
    .clk(clk), .rst(rst), .data_i(data), .valid_i(valid), .div_i(div),
    .line_o(line), .ready_o(ready), .done_o(done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic slot_val(input logic [W-1:0] w, input int j);
    int k;
    if (j < PRE) return 1'b1;
    if (j == PRE) return 1'b0;
    k = j - PRE - 1;
    return (k % 2 == 0) ? !w[k/2] : w[k/2];
  endfunction

  task automatic run_frame(input logic [W-1:0] w, input int d, input bit poke);
    @(negedge clk);
    data = w; div = DW'(d); valid = 1;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    for (int j = 0; j < S; j++) begin
      for (int c = 0; c <= d; c++) begin
        // R2 R3 R4 R5: per-cycle slot value and duration
        chk($sformatf("R3/R4/R5/R2 w=%h d=%0d slot %0d cyc %0d", w, d, j, c), line, slot_val(w, j));
        chk("R6 ready low during frame", ready, 1'b0);
        chk("R6 done low during frame", done, 1'b0);
        if (poke && j == 6 && c == 0) begin
          // R7 R8: load attempt and divider change while busy
          valid = 1; data = ~w; div = DW'(d + 3);
        end
        if (poke && j == 8 && c == 0) valid = 0;
        @(negedge clk);
      end
    end
    chk("R6 done pulse at frame end", done, 1'b1);
    chk("R6 ready back at frame end", ready, 1'b1);
    chk("R7 line idles high", line, 1'b1);
    @(negedge clk);
    chk("R6 done lasts one cycle", done, 1'b0);
    chk("R7 line idles high after done", line, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 line after reset", line, 1'b1);
    chk("R1 ready after reset", ready, 1'b1);
    chk("R1 done after reset", done, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R7 idle line", line, 1'b1);

    for (int w = 0; w < 256; w++) run_frame(W'(w), 0, 0);
    for (int d = 1; d <= 5; d += 2) begin
      run_frame(8'h00, d, 0);
      run_frame(8'hFF, d, 0);
      run_frame(8'hA5, d, 0);
      run_frame(8'h01, d, 0);
      run_frame(8'h80, d, 0);
    end
    run_frame(8'h3C, 2, 1);
    run_frame(8'hC1, 0, 1);

    // R1 mid-frame reset
    @(negedge clk);
    data = 8'h00; div = 8'd4; valid = 1;
    @(negedge clk);
    valid = 0;
    repeat (23) @(negedge clk);
    chk("R1 frame running before reset", ready, 1'b0);
    rst = 1;
    @(negedge clk);
    chk("R1 line high after mid-frame reset", line, 1'b1);
    chk("R1 ready high after mid-frame reset", ready, 1'b1);
    chk("R1 no done on reset", done, 1'b0);
    rst = 0;
    run_frame(8'h96, 3, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog: actual hung, expected frames to finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule